// File: doc/BRIEF.md
# One's Complement Adder-Subtractor

A combinational block that adds or subtracts two unsigned operands of equal width using one's-complement arithmetic. For subtraction the second operand is inverted before a carry-chain add; the carry leaving the top of the chain is the end-around carry. The result leaves the block as an unsigned magnitude plus a separate sign bit (1 = negative), not as a raw sum.

The operation is chosen either at run time by a 1-bit input or at build time by a parameter. A parameter selects which one applies, and when the run-time input is enabled it overrides the static setting. A second parameter makes the block export the end-around carry on its own output instead of adding it back into the sum. A later stage can then absorb the +1 correction: in that case the magnitude output is one less than the true magnitude whenever the exported carry is high. The two operand widths are separate parameters only so that a mismatch can be caught: differing widths stop elaboration with an error.

The block has no clock and no state. Its flow is fixed: operand preparation, carry chain, then result fix-up. The fix-up either negates the raw sum, adds the carry back in, or exports the carry.

Top module: `ones_addsub`

## Requirements
- R1: With carry export off and subtraction selected, `mag_o` equals |a - b| and `sign_o` is 1 exactly when a < b.
- R2: With addition selected, `sign_o` is 0. With carry export off, `mag_o` equals a + b when a + b < 2^W, and a + b - 2^W + 1 otherwise.
- R3: With carry export on, `carry_o` carries the end-around carry and is not folded in. When it is 1, `mag_o` is one less than the true magnitude. In every case `mag_o + carry_o` equals the magnitude that R1 or R2 gives.
- R4: With carry export off, `carry_o` is always 0.
- R5: Subtracting equal operands gives `mag_o` = 0 and `sign_o` = 0, and with carry export on also `carry_o` = 0.
- R6: With the run-time select enabled (`USE_SUB_PIN` = 1), `sub_i` = 1 selects subtraction and `sub_i` = 0 selects addition. This holds even when `STATIC_SUB` requests the other operation.
- R7: With the run-time select disabled (`USE_SUB_PIN` = 0), `sub_i` has no effect and `STATIC_SUB` (1 = subtract) chooses the operation.
- R8: With carry export on, `carry_o` and `sign_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | A_WIDTH | First unsigned operand (minuend) |
| b_i | input | B_WIDTH | Second unsigned operand (subtrahend); must match A_WIDTH |
| sub_i | input | 1 | Run-time operation select, 1 = subtract; used only when USE_SUB_PIN = 1 |
| mag_o | output | A_WIDTH | Unsigned result magnitude |
| sign_o | output | 1 | Result sign, 1 = negative |
| carry_o | output | 1 | Exported end-around carry; 0 when export is off |

## Verification
The block is purely combinational, so a wrong internal value shows at the ports in the same evaluation as the input change that exposes it. No later cycle is needed to reveal it. A wrong inversion or a broken carry link skews the magnitude for particular operand pairs. A wrong end-around decision shows as an off-by-one magnitude, a spurious carry, or a negative zero on equal operands. Every operand pair of a 4-bit build is therefore swept in both operations, with export on and off, and with the static select.

// File: rtl/ones_addsub_pkg.sv
package ones_addsub_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;
endpackage

// File: rtl/ones_operand_prep.sv
module ones_operand_prep
    import ones_addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] b_in,
    input  op_e          op,
    output logic [W-1:0] b_eff
);
    always_comb begin
        unique case (op)
            OP_SUB:  b_eff = ~b_in;
            default: b_eff = b_in;
        endcase
    end
endmodule

// File: rtl/ones_ripple_chain.sv
module ones_ripple_chain #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] c;
    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = x[i] ^ y[i] ^ c[i];
        assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
    end

    assign cout = c[W];
endmodule

// File: rtl/ones_result_fix.sv
module ones_result_fix
    import ones_addsub_pkg::*;
#(
    parameter int W            = 8,
    parameter bit EXPORT_CARRY = 1'b0
) (
    input  logic [W-1:0] raw,
    input  logic         eac,
    input  op_e          op,
    output logic [W-1:0] mag,
    output logic         sign,
    output logic         carry
);
    logic          negative;
    logic [W-1:0]  neg_mag;

    assign negative = (op == OP_SUB) && !eac;
    assign neg_mag  = ~raw;

    if (EXPORT_CARRY) begin : g_export
        always_comb begin
            if (negative) begin
                mag   = neg_mag;
                sign  = (neg_mag != '0);
                carry = 1'b0;
            end else begin
                mag   = raw;
                sign  = 1'b0;
                carry = eac;
            end
        end
    end else begin : g_fold
        always_comb begin
            carry = 1'b0;
            if (negative) begin
                mag  = neg_mag;
                sign = (neg_mag != '0);
            end else begin
                mag  = raw + {{(W-1){1'b0}}, eac};
                sign = 1'b0;
            end
        end
    end
endmodule

// File: rtl/ones_addsub.sv
module ones_addsub
    import ones_addsub_pkg::*;
#(
    parameter int A_WIDTH      = 8,
    parameter int B_WIDTH      = 8,
    parameter bit USE_SUB_PIN  = 1'b1,
    parameter bit STATIC_SUB   = 1'b0,
    parameter bit EXPORT_CARRY = 1'b0
) (
    input  logic [A_WIDTH-1:0] a_i,
    input  logic [B_WIDTH-1:0] b_i,
    input  logic               sub_i,
    output logic [A_WIDTH-1:0] mag_o,
    output logic               sign_o,
    output logic               carry_o
);
    localparam int W = A_WIDTH;

    if (A_WIDTH != B_WIDTH) begin : g_width_bad
        $error("ones_addsub: operand widths differ");
    end

    op_e          op;
    logic [W-1:0] b_eff;
    logic [W-1:0] raw;
    logic         eac;

    if (USE_SUB_PIN) begin : g_pin_sel
        assign op = sub_i ? OP_SUB : OP_ADD;
    end else begin : g_static_sel
        logic unused_sub;
        assign unused_sub = sub_i;
        assign op = STATIC_SUB ? OP_SUB : OP_ADD;
    end

    ones_operand_prep #(.W(W)) u_prep (
        .b_in  (b_i),
        .op    (op),
        .b_eff (b_eff)
    );

    ones_ripple_chain #(.W(W)) u_chain (
        .x    (a_i),
        .y    (b_eff),
        .sum  (raw),
        .cout (eac)
    );

    ones_result_fix #(.W(W), .EXPORT_CARRY(EXPORT_CARRY)) u_fix (
        .raw   (raw),
        .eac   (eac),
        .op    (op),
        .mag   (mag_o),
        .sign  (sign_o),
        .carry (carry_o)
    );
endmodule

// File: rtl/ones_addsub_chk.sv
module ones_addsub_chk #(
    parameter int A_WIDTH      = 8,
    parameter int B_WIDTH      = 8,
    parameter bit USE_SUB_PIN  = 1'b1,
    parameter bit STATIC_SUB   = 1'b0,
    parameter bit EXPORT_CARRY = 1'b0
) (
    input logic [A_WIDTH-1:0] a_i,
    input logic [B_WIDTH-1:0] b_i,
    input logic               sub_i,
    input logic [A_WIDTH-1:0] mag_o,
    input logic               sign_o,
    input logic               carry_o
);
    localparam int W = A_WIDTH;

    logic         do_sub;
    logic [W:0]   wa, wb, diff_abs, total;

    always_comb begin
        do_sub   = USE_SUB_PIN ? sub_i : STATIC_SUB;
        wa       = {1'b0, a_i};
        wb       = {1'b0, b_i[W-1:0]};
        diff_abs = (wa >= wb) ? (wa - wb) : (wb - wa);
        total    = {1'b0, mag_o} + {{W{1'b0}}, carry_o};

        // R2
        add_sign_chk: assert (do_sub || !sign_o);

        // R1
        if (!EXPORT_CARRY && do_sub)
            sub_result_chk: assert (({1'b0, mag_o} == diff_abs) && (sign_o == (wa < wb)));

        // R3
        if (EXPORT_CARRY && do_sub)
            export_recon_chk: assert (total == diff_abs);

        // R5
        if (do_sub && (wa == wb))
            equal_zero_chk: assert ((mag_o == '0) && !sign_o && !carry_o);

        // R8
        if (EXPORT_CARRY)
            carry_sign_excl_chk: assert (!(carry_o && sign_o));
    end
endmodule

bind ones_addsub ones_addsub_chk #(
    .A_WIDTH      (A_WIDTH),
    .B_WIDTH      (B_WIDTH),
    .USE_SUB_PIN  (USE_SUB_PIN),
    .STATIC_SUB   (STATIC_SUB),
    .EXPORT_CARRY (EXPORT_CARRY)
) u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (sub_i),
    .mag_o   (mag_o),
    .sign_o  (sign_o),
    .carry_o (carry_o)
);

// File: tb/sim_ones_addsub.sv
module sim_ones_addsub;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int SPAN       = 1 << W;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W-1:0] a, b;
    logic         sub;
    logic [W-1:0] mag0, mag1, mag2;
    logic         sign0, sign1, sign2, car0, car1, car2;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    ones_addsub #(.A_WIDTH(W), .B_WIDTH(W), .USE_SUB_PIN(1'b1), .STATIC_SUB(1'b0),
                  .EXPORT_CARRY(1'b0)) u0 (
        .a_i(a), .b_i(b), .sub_i(sub), .mag_o(mag0), .sign_o(sign0), .carry_o(car0));

    ones_addsub #(.A_WIDTH(W), .B_WIDTH(W), .USE_SUB_PIN(1'b1), .STATIC_SUB(1'b0),
                  .EXPORT_CARRY(1'b1)) u1 (
        .a_i(a), .b_i(b), .sub_i(sub), .mag_o(mag1), .sign_o(sign1), .carry_o(car1));

    ones_addsub #(.A_WIDTH(W), .B_WIDTH(W), .USE_SUB_PIN(1'b0), .STATIC_SUB(1'b1),
                  .EXPORT_CARRY(1'b0)) u2 (
        .a_i(a), .b_i(b), .sub_i(sub), .mag_o(mag2), .sign_o(sign2), .carry_o(car2));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s a=%0d b=%0d sub=%0d actual=%0d expected=%0d",
                     req, a, b, sub, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; sub = 1'b0;
        #(CLK_PERIOD/2 + 1);
        chk("R2 initial sign", int'(sign0), 0);
        chk("R4 initial carry", int'(car0), 0);

        for (int s = 0; s < 2; s++) begin
            for (int ia = 0; ia < SPAN; ia++) begin
                for (int ib = 0; ib < SPAN; ib++) begin
                    int absd, sum, em, ecarry;
                    @(negedge clk);
                    a = W'(ia); b = W'(ib); sub = s[0];
                    #1;
                    absd   = (ia >= ib) ? ia - ib : ib - ia;
                    sum    = ia + ib;
                    em     = (sum >= SPAN) ? sum - SPAN + 1 : sum;
                    ecarry = (sum >= SPAN) ? 1 : 0;

                    chk("R4 carry off", int'(car0), 0);
                    if (s == 1) begin
                        chk("R1/R6 sub mag", int'(mag0), absd);
                        chk("R1/R6 sub sign", int'(sign0), (ia < ib) ? 1 : 0);
                        chk("R3 sub recon", int'(mag1) + int'(car1), absd);
                        chk("R3 sub carry", int'(car1), (ia > ib) ? 1 : 0);
                        chk("R3 sub sign", int'(sign1), (ia < ib) ? 1 : 0);
                        if (ia == ib) begin
                            chk("R5 eq mag fold", int'(mag0), 0);
                            chk("R5 eq sign fold", int'(sign0), 0);
                            chk("R5 eq mag exp", int'(mag1), 0);
                            chk("R5 eq sign exp", int'(sign1), 0);
                            chk("R5 eq carry exp", int'(car1), 0);
                        end
                    end else begin
                        chk("R2/R6 add mag", int'(mag0), em);
                        chk("R2/R6 add sign", int'(sign0), 0);
                        chk("R3 add recon", int'(mag1) + int'(car1), em);
                        chk("R3 add carry", int'(car1), ecarry);
                        chk("R2 add sign exp", int'(sign1), 0);
                    end
                    chk("R8 carry/sign excl", int'(car1 & sign1), 0);
                    chk("R7 static mag", int'(mag2), absd);
                    chk("R7 static sign", int'(sign2), (ia < ib) ? 1 : 0);
                    chk("R7 static carry", int'(car2), 0);
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule